// File: doc/BRIEF.md
# Serial Dual-Channel DAC Command Front End

This block is the digital side of a two-channel 12-bit converter. A host writes 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The block samples all three lines in a faster system clock domain. It shifts the bits in and decodes a two-bit destination field. It then updates the channel A code, the channel B code, a channel B staging register or a small configuration register. It drives the two 12-bit codes, a fast-settling flag, a power-down flag and a two-bit reference selector to the analog section.

Channel B is double-buffered. A host can stage a value for B, then write A, and both codes change in the same system clock cycle. The fast and power-down flags are carried in every command word, whatever its destination.

Top module: `sdac_front`

## Requirements
- R1: After reset, both channel codes, the staging register, the reference selector and both flags are zero.
- R2: A frame begins when the select line goes low. Data bits are taken on falling serial clock edges, most significant bit first, so the first bit sent lands in word bit 15.
- R3: Destination field {bit15, bit12} = 00 writes data bits 11..0 to both channel B and the staging register.
- R4: Destination 01 writes only the staging register. The channel B output stays unchanged until a later destination-10 word copies the staged value out.
- R5: Destination 10 writes data bits 11..0 to channel A. In the same cycle it copies the staging register to channel B.
- R6: Destination 11 sets the reference selector to data bits 1..0 (00 external, 01 low internal, 10 high internal, 11 external). Data bits 11..2 are ignored, and both channel codes stay unchanged.
- R7: Every committed word sets the fast flag from bit 14 and the power-down flag from bit 13, for any destination.
- R8: A word commits once its 16th bit has been taken. Further serial clock edges before the select line rises are ignored.
- R9: If the select line rises after 1 to 15 bits, the partial word commits. The bits received sit in the low positions of the word, and the upper positions are zero.
- R10: If the select line falls and rises with no serial clock edge in between, no output changes.
- R11: Outputs change only in the system cycle that follows a commit, and each frame commits at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| dac_a_o | output | 12 | Channel A code |
| dac_b_o | output | 12 | Channel B code |
| fast_o | output | 1 | Fast-settling mode flag |
| pdown_o | output | 1 | Power-down flag |
| ref_sel_o | output | 2 | Reference source code |

## Verification
The bench stages a channel B value and shows that the output holds until a channel A write moves it. A design that wired staging straight to the output would show the new B value one word early. It sends trailing serial clock edges after a complete word; a design that kept shifting would commit a corrupted, shifted word when the select line rises. It also sends short frames and empty frames. A design that ignored the select line edge would lose the partial word, and one that committed on every select edge would clobber channel B with zero on an empty frame. Junk in the upper data bits of a configuration word catches a decoder that leaks those bits into the channel codes or misreads the reference code.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DATA_W = 12;
  localparam int WORD_W = DATA_W + 4;
  localparam int REF_W  = 2;

  typedef enum logic [1:0] {
    DST_B_AND_STAGE = 2'b00,
    DST_STAGE_ONLY  = 2'b01,
    DST_A_AND_MOVE  = 2'b10,
    DST_CONFIG      = 2'b11
  } dst_e;

  // destination bits are split: bit 15 is the high bit, bit 12 the low bit
  function automatic dst_e dst_of(input logic [WORD_W-1:0] w);
    return dst_e'({w[WORD_W-1], w[WORD_W-4]});
  endfunction

  function automatic logic [DATA_W-1:0] data_of(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic fast_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-2];
  endfunction

  function automatic logic pdown_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-3];
  endfunction

  function automatic logic [REF_W-1:0] ref_of(input logic [WORD_W-1:0] w);
    return w[REF_W-1:0];
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= async_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              csn_q, sclk_q, active;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              cs_fall, cs_rise, sck_fall;

  assign cs_fall  = csn_q & ~csn_s;
  assign cs_rise  = ~csn_q & csn_s;
  assign sck_fall = sclk_q & ~sclk_s & ~csn_s & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q    <= 1'b1;
      sclk_q   <= 1'b0;
      active   <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      commit_o <= 1'b0;
    end else begin
      csn_q    <= csn_s;
      sclk_q   <= sclk_s;
      commit_o <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        sh     <= '0;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (cnt != '0 && cnt != FULL) commit_o <= 1'b1;
      end else if (sck_fall && cnt != FULL) begin
        sh  <= {sh[WORD_W-2:0], sdi_s};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) commit_o <= 1'b1;
      end
    end
  end

  assign word_o = sh;
  assign cnt_o  = cnt;
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic [DATA_W-1:0] stage_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic [REF_W-1:0]  ref_o
);
  dst_e              dst;
  logic [DATA_W-1:0] dat;

  assign dst = dst_of(word_i);
  assign dat = data_of(word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_a_o <= '0;
      dac_b_o <= '0;
      stage_o <= '0;
      fast_o  <= 1'b0;
      pdown_o <= 1'b0;
      ref_o   <= '0;
    end else if (commit_i) begin
      fast_o  <= fast_of(word_i);
      pdown_o <= pdown_of(word_i);
      unique case (dst)
        DST_B_AND_STAGE: begin
          dac_b_o <= dat;
          stage_o <= dat;
        end
        DST_STAGE_ONLY: stage_o <= dat;
        DST_A_AND_MOVE: begin
          dac_a_o <= dat;
          dac_b_o <= stage_o;
        end
        default: ref_o <= ref_of(word_i);
      endcase
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic [REF_W-1:0]  ref_sel_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word_w;
  logic              commit_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0] stage_w;

  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({csn_i, sclk_i, sdi_i}),
    .sync_o(pins_s)
  );

  sdac_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .csn_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .word_o(word_w), .commit_o(commit_w), .cnt_o(cnt_w)
  );

  sdac_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit_w), .word_i(word_w),
    .dac_a_o(dac_a_o), .dac_b_o(dac_b_o), .stage_o(stage_w),
    .fast_o(fast_o), .pdown_o(pdown_o), .ref_o(ref_sel_o)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
#(
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [WORD_W-1:0] word,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] stage,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              fast,
  input logic              pdown,
  input logic [REF_W-1:0]  refsel
);
  // R5
  a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && dst_of(word) == DST_A_AND_MOVE |=> dac_a == $past(data_of(word)) && dac_b == $past(stage));
  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && dst_of(word) == DST_CONFIG) |=> $stable(refsel));
  // R11
  b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(dac_b) && $stable(dac_a));
  // R11
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));
  // R7
  flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> fast == $past(word[WORD_W-2]) && pdown == $past(word[WORD_W-3]));
endmodule

bind sdac_front sdac_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit_w), .word(word_w), .cnt(cnt_w),
  .stage(stage_w), .dac_a(dac_a_o), .dac_b(dac_b_o), .fast(fast_o),
  .pdown(pdown_o), .refsel(ref_sel_o)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] dac_a, dac_b;
  logic fast, pdown;
  logic [1:0] refsel;

  int total = 0, bad = 0;
  logic [11:0] ma = '0, mb = '0, mst = '0;
  logic mf = 1'b0, mp = 1'b0;
  logic [1:0] mr = '0;

  always #5 clk = ~clk;

  sdac_front u0 (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .fast_o(fast), .pdown_o(pdown),
    .ref_sel_o(refsel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    @(negedge clk);
    chk(req, "dac_a", int'(dac_a), int'(ma));
    chk(req, "dac_b", int'(dac_b), int'(mb));
    chk(req, "fast", int'(fast), int'(mf));
    chk(req, "pdown", int'(pdown), int'(mp));
    chk(req, "ref", int'(refsel), int'(mr));
  endtask

  // bench model of a committed word
  task automatic model(input logic [15:0] w);
    mf = w[14];
    mp = w[13];
    case ({w[15], w[12]})
      2'b00: begin mb = w[11:0]; mst = w[11:0]; end
      2'b01: mst = w[11:0];
      2'b10: begin ma = w[11:0]; mb = mst; end
      default: mr = w[1:0];
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the first nbits of w MSB first, then extra clock edges with data high
  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    csn = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdi = w[15-i]; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
      if (i == 14 && nbits == 16) chk_all("R11 mid-frame");
    end
    for (int i = 0; i < extra; i++) begin
      sclk = 1'b1; sdi = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    csn = 1'b1;
    wait_clk(10);
    if (nbits == 16) model(w);
    else if (nbits > 0) model(w >> (16 - nbits));
  endtask

  task automatic t_reset;
    chk_all("R1 reset");
  endtask

  task automatic t_config;
    send(16'hDFF6, 16, 0);     // dest 11, fast=1, ref=10, junk upper data
    chk_all("R6 R7 config");
    chk("R6", "ref high internal", int'(refsel), 2);
    send(16'h9001, 16, 0);     // dest 11, fast=0, ref=01
    chk_all("R6 ref low internal");
  endtask

  task automatic t_b_and_stage;
    send(16'h0ABC, 16, 0);
    chk_all("R2 R3 b and stage");
    chk("R3", "dac_b", int'(dac_b), 12'hABC);
  endtask

  task automatic t_stage_then_move;
    send(16'h1555, 16, 0);
    chk_all("R4 stage only");
    chk("R4", "dac_b held", int'(dac_b), 12'hABC);
    send(16'hA123, 16, 0);     // dest 10, power-down set
    chk_all("R5 R7 move");
    chk("R5", "dac_b from stage", int'(dac_b), 12'h555);
    chk("R7", "pdown", int'(pdown), 1);
  endtask

  task automatic t_extra_edges;
    send(16'h0F0F, 16, 5);
    chk_all("R8 extra edges");
    chk("R8", "dac_b", int'(dac_b), 12'hF0F);
  endtask

  task automatic t_partial;
    send(16'h9876, 8, 0);      // commits 0x0098
    chk_all("R9 partial");
    chk("R9", "dac_b", int'(dac_b), 12'h098);
    send(16'hC000, 3, 0);      // commits 0x0006
    chk_all("R9 short partial");
  endtask

  task automatic t_empty;
    send(16'hFFFF, 0, 0);
    chk_all("R10 empty frame");
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_config();
    t_b_and_stage();
    t_stage_then_move();
    t_extra_edges();
    t_partial();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule